// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Compare and Event Output

This block is a free-running up-counter with a programmable clock divider. Optionally it reloads from a holding register each time it rolls past its maximum value. It compares the count against a programmable value and drives a single event pin. A control word sets the divider, the reload behaviour, the compare enable and the pin behaviour. Separate write strobes update the reload value, the compare value and the count itself. A trigger strobe copies the reload value into the counter at once.

The block produces one-cycle overflow and compare-hit pulses, which a separate interrupt block consumes. It also produces the level of the event pin, together with an output-enable that follows the pin direction bit. The pin can invert on each selected event, or it can give a one-cycle inverted pulse. When no event is selected, or the timer is stopped, the pin sits at a programmed resting level.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count is 0, the timer is stopped, both event pulses are low, the pin level is 0 and the pin output-enable is 1.
- R2: While running (control bit 0 = 1) the count grows by exactly one per divider tick. While stopped, or in a cycle that carries a control, count or trigger write, it holds.
- R3: With the divider enabled (control bit 5 = 1) a tick occurs once every 2^(p+1) clock cycles, where p is control bits 4:2. With the divider disabled a tick occurs every cycle. Writing control, count or trigger restarts the divider phase, so the first tick lands 2^(p+1) cycles after the write.
- R4: A tick taken at count 0xFFFFFFFF raises `ovfEvt` for one cycle. It sets the count to the reload value when auto-reload (control bit 1) is 1, and to 0 otherwise.
- R5: `matEvt` rises for one cycle only when compare is enabled (control bit 6 = 1) and a tick moves the count onto the compare value. A direct count write never raises it.
- R6: A trigger write loads the counter with the reload value, and a count write loads it with the bus data. When both occur in the same cycle, the count write wins.
- R7: While stopped, or when the trigger mode (control bits 11:10) is 0, the pin settles at the resting level given by control bit 7.
- R8: Trigger mode 1 selects overflow events only. Modes 2 and 3 select both overflow and compare-hit events. With control bit 12 = 0 the pin inverts once for each tick that carries a selected event.
- R9: With control bit 12 = 1 a tick carrying a selected event inverts the pin for exactly the one cycle that follows, after which the pin returns to its held level.
- R10: With control bit 14 = 1 (pin is an input) `pinOe` is 0 and `pinOut` is 0. With bit 14 = 0, `pinOe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Write strobe for the control word |
| ctrlData | input | 15 | Control word |
| loadWe | input | 1 | Write strobe for the reload register |
| matchWe | input | 1 | Write strobe for the compare register |
| cntWe | input | 1 | Write strobe for the counter |
| trigWe | input | 1 | Trigger strobe: counter takes the reload value |
| wrData | input | 32 | Data for reload, compare and counter writes |
| count | output | 32 | Current counter value |
| ovfEvt | output | 1 | One-cycle overflow pulse |
| matEvt | output | 1 | One-cycle compare-hit pulse |
| pinOut | output | 1 | Event pin level |
| pinOe | output | 1 | Event pin output-enable |

## Verification
The situation hardest to reach from the ports is an overflow that happens at every divider setting while the pin is in each of its modes. A 32-bit counter never wraps in a short run. The stimulus therefore stops the timer and writes the count a few steps below the top. It sets a reload value just under the top, so that auto-reload produces repeated wraps, and places the compare value between them. It then starts the timer and walks every divider setting against every pin mode. The bench predicts every cycle's count, pulses and pin level arithmetically from the tick spacing 2^(p+1).

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int CTRL_W = 15;
  localparam int PTV_W  = 3;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_OVF  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_ALT  = 2'd3
  } trig_e;

  typedef struct packed {
    logic             start;
    logic             autoReload;
    logic [PTV_W-1:0] ptv;
    logic             preEn;
    logic             cmpEn;
    logic             restLvl;
    trig_e            trig;
    logic             pulseMode;
    logic             pinIn;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic useLoad;
    logic useBus;
    logic autoReload;
    logic cmpEn;
  } strobe_t;

endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              cntWe,
  input  logic              trigWe,
  input  logic              ovfHit,
  input  logic              matHit,
  output strobe_t           strb,
  output logic              pinOut,
  output logic              pinOe
);

  localparam int PRE_W = 1 << PTV_W;
  localparam logic [PRE_W-1:0] PRE_ONES = '1;

  cfg_t             cfg;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             anyWrite;
  logic             tick;
  logic             evtSel;
  logic             idleOut;
  logic             lvlQ;
  logic             pulseQ;
  logic             unusedBits;

  assign unusedBits = ^{ctrlData[13], ctrlData[9:8]};

  // Control word register: fields at fixed bit positions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (ctrlWe) begin
      cfg.start      <= ctrlData[0];
      cfg.autoReload <= ctrlData[1];
      cfg.ptv        <= ctrlData[4:2];
      cfg.preEn      <= ctrlData[5];
      cfg.cmpEn      <= ctrlData[6];
      cfg.restLvl    <= ctrlData[7];
      cfg.trig       <= trig_e'(ctrlData[11:10]);
      cfg.pulseMode  <= ctrlData[12];
      cfg.pinIn      <= ctrlData[14];
    end
  end

  // Divider: terminal count is 2^(ptv+1)-1
  assign preLim   = PRE_ONES >> (PTV_W'(PRE_W - 1) - cfg.ptv);
  assign anyWrite = ctrlWe | cntWe | trigWe;
  assign tick     = cfg.start && !anyWrite && (!cfg.preEn || preCnt == preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!cfg.start || anyWrite || tick) begin
      preCnt <= '0;
    end else if (cfg.preEn) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign strb.tick       = tick;
  assign strb.useLoad    = trigWe;
  assign strb.useBus     = cntWe;
  assign strb.autoReload = cfg.autoReload;
  assign strb.cmpEn      = cfg.cmpEn;

  // Event selection and pin shaping
  assign idleOut = !cfg.start || (cfg.trig == TRIG_NONE);
  assign evtSel  = tick && ((cfg.trig != TRIG_NONE && ovfHit) ||
                            (cfg.trig[1] && matHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else if (idleOut) begin
      lvlQ   <= cfg.restLvl;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= evtSel && cfg.pulseMode;
      if (evtSel && !cfg.pulseMode) lvlQ <= ~lvlQ;
    end
  end

  assign pinOe  = !cfg.pinIn;
  assign pinOut = pinOe ? (lvlQ ^ pulseQ) : 1'b0;

  // R3: with the divider on, ticks are never back to back
  p_prescale_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cfg.preEn && !ctrlWe) |=> !tick);

  // R7: idle pin settles at the resting level
  p_rest_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    idleOut |=> (lvlQ == $past(cfg.restLvl) && !pulseQ));

  // R8: toggle mode inverts on every selected event
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!idleOut && evtSel && !cfg.pulseMode) |=> (lvlQ != $past(lvlQ)));

  // R9: pulse mode never moves the held level
  p_pulse_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!idleOut && cfg.pulseMode) |=> (lvlQ == $past(lvlQ)));

endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             loadWe,
  input  logic             matchWe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             ovfHit,
  output logic             matHit,
  output logic             ovfEvt,
  output logic             matEvt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] loadR;
  logic [CNT_W-1:0] matchR;
  logic [CNT_W-1:0] nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadR  <= '0;
      matchR <= '0;
    end else begin
      if (loadWe)  loadR  <= wrData;
      if (matchWe) matchR <= wrData;
    end
  end

  assign ovfHit = (count == CNT_MAX);
  assign nxt    = ovfHit ? (strb.autoReload ? loadR : '0) : count + 1'b1;
  assign matHit = strb.cmpEn && (nxt == matchR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      ovfEvt <= 1'b0;
      matEvt <= 1'b0;
    end else begin
      if (strb.useBus)       count <= wrData;
      else if (strb.useLoad) count <= loadR;
      else if (strb.tick)    count <= nxt;
      ovfEvt <= strb.tick && ovfHit;
      matEvt <= strb.tick && matHit;
    end
  end

  // R2: no tick and no write keeps the count
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.useBus && !strb.useLoad) |=> (count == $past(count)));

  // R2: a tick below the top adds one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.useBus && !strb.useLoad && count != CNT_MAX)
      |=> (count == $past(count) + 1'b1));

  // R4: overflow pulse follows the top value and lands on reload or zero
  p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |-> ($past(count) == CNT_MAX &&
                count == ($past(strb.autoReload) ? $past(loadR) : '0)));

  // R5: compare pulse only with compare enabled and count on the value
  p_match_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    matEvt |-> ($past(strb.cmpEn) && count == $past(matchR)));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              loadWe,
  input  logic              matchWe,
  input  logic              cntWe,
  input  logic              trigWe,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  count,
  output logic              ovfEvt,
  output logic              matEvt,
  output logic              pinOut,
  output logic              pinOe
);

  strobe_t strb;
  logic    ovfHit;
  logic    matHit;

  ptmr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlData (ctrlData),
    .cntWe    (cntWe),
    .trigWe   (trigWe),
    .ovfHit   (ovfHit),
    .matHit   (matHit),
    .strb     (strb),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );

  ptmr_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadWe  (loadWe),
    .matchWe (matchWe),
    .wrData  (wrData),
    .count   (count),
    .ovfHit  (ovfHit),
    .matHit  (matHit),
    .ovfEvt  (ovfEvt),
    .matEvt  (matEvt)
  );

  // R10: an input-direction pin is never driven
  p_pin_input_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinOut);

endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0, loadWe = 1'b0, matchWe = 1'b0, cntWe = 1'b0, trigWe = 1'b0;
  logic [14:0] ctrlData = '0;
  logic [31:0] wrData = '0;
  logic [31:0] count;
  logic        ovfEvt, matEvt, pinOut, pinOe;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .loadWe(loadWe), .matchWe(matchWe), .cntWe(cntWe), .trigWe(trigWe),
    .wrData(wrData), .count(count), .ovfEvt(ovfEvt), .matEvt(matEvt),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] cw(input bit dir, input bit pt, input logic [1:0] trig,
                                     input bit rest, input bit ce, input bit pre,
                                     input logic [2:0] ptv, input bit ar, input bit st);
    return {dir, 1'b0, pt, trig, 2'b00, rest, ce, pre, ptv, ar, st};
  endfunction

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [14:0] v);
    ctrlData = v; ctrlWe = 1'b1; edge1(); ctrlWe = 1'b0;
  endtask
  task automatic wrLoad(input logic [31:0] v);
    wrData = v; loadWe = 1'b1; edge1(); loadWe = 1'b0;
  endtask
  task automatic wrMatch(input logic [31:0] v);
    wrData = v; matchWe = 1'b1; edge1(); matchWe = 1'b0;
  endtask
  task automatic wrCnt(input logic [31:0] v);
    wrData = v; cntWe = 1'b1; edge1(); cntWe = 1'b0;
  endtask

  // One run: configure while stopped, start, predict every cycle
  task automatic runCase(input int ps, input int k);
    bit pre = (ps < 8);
    logic [2:0] ptv = 3'(ps);
    int div = pre ? (1 << (ps + 1)) : 1;
    logic [1:0] trig; bit pt, ar, ce, rest;
    logic [31:0] ec, ld, mv;
    bit lvl, pls, eo, em, sel;
    case (k)
      0: begin trig = 2'd1; pt = 0; ar = 1; ce = 1; rest = 0; end
      1: begin trig = 2'd2; pt = 0; ar = 0; ce = 1; rest = 1; end
      2: begin trig = 2'd3; pt = 1; ar = 1; ce = 1; rest = 0; end
      3: begin trig = 2'd2; pt = 1; ar = 0; ce = 0; rest = 1; end
      4: begin trig = 2'd0; pt = 0; ar = 1; ce = 1; rest = 1; end
      default: begin trig = 2'd1; pt = 1; ar = 1; ce = 0; rest = 0; end
    endcase
    ec = 32'hFFFF_FFFE; ld = 32'hFFFF_FFFD; mv = 32'hFFFF_FFFE;
    wrCtrl(cw(0, pt, trig, rest, ce, pre, ptv, ar, 0));
    wrLoad(ld); wrMatch(mv); wrCnt(ec);
    chk("R7 stopped rest level", 32'(pinOut), 32'(rest));
    wrCtrl(cw(0, pt, trig, rest, ce, pre, ptv, ar, 1));
    lvl = rest; pls = 0;
    for (int m = 1; m <= 4 * div + 3; m++) begin
      edge1();
      eo = 0; em = 0; pls = 0;
      if (m % div == 0) begin
        if (ec == 32'hFFFF_FFFF) begin eo = 1; ec = ar ? ld : 32'h0; end
        else ec = ec + 1;
        em = ce && (ec == mv);
        sel = (trig != 0 && eo) || (trig[1] && em);
        if (trig == 0) lvl = rest;
        else if (sel) begin
          if (pt) pls = 1; else lvl = ~lvl;
        end
      end
      chk("R2 R3 R4 count", count, ec);
      chk("R4 ovfEvt", 32'(ovfEvt), 32'(eo));
      chk("R5 matEvt", 32'(matEvt), 32'(em));
      chk("R8 R9 pin", 32'(pinOut), 32'(lvl ^ pls));
    end
    // Stop: count holds and pin returns to rest
    wrCtrl(cw(0, pt, trig, rest, ce, pre, ptv, ar, 0));
    edge1(); edge1();
    chk("R2 stopped hold", count, ec);
    chk("R7 rest after stop", 32'(pinOut), 32'(rest));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    edge1(); edge1();
    // R1 reset state
    chk("R1 count", count, 32'h0);
    chk("R1 ovfEvt", 32'(ovfEvt), 32'h0);
    chk("R1 matEvt", 32'(matEvt), 32'h0);
    chk("R1 pinOut", 32'(pinOut), 32'h0);
    chk("R1 pinOe", 32'(pinOe), 32'h1);
    rstN = 1'b1;
    edge1(); edge1();
    chk("R1 stays stopped", count, 32'h0);

    for (int ps = 0; ps <= 8; ps++)
      for (int k = 0; k < 6; k++) runCase(ps, k);

    // R6: trigger and count writes while stopped
    wrCtrl(cw(0, 0, 2'd0, 0, 0, 0, 3'd0, 0, 0));
    wrLoad(32'h1234_5678);
    wrCnt(32'h0000_0010);
    chk("R6 count write", count, 32'h0000_0010);
    trigWe = 1'b1; edge1(); trigWe = 1'b0;
    chk("R6 trigger load", count, 32'h1234_5678);
    wrData = 32'hAAAA_0001; cntWe = 1'b1; trigWe = 1'b1; edge1();
    cntWe = 1'b0; trigWe = 1'b0;
    chk("R6 count write wins", count, 32'hAAAA_0001);

    // R3: count write restarts the divider phase (divide by 4)
    wrCtrl(cw(0, 0, 2'd0, 0, 0, 1, 3'd1, 0, 1));
    edge1(); edge1();
    wrCnt(32'h0000_0100);
    for (int m = 1; m <= 4; m++) begin
      edge1();
      chk("R3 phase restart", count, (m == 4) ? 32'h0000_0101 : 32'h0000_0100);
    end

    // R5: count written onto the compare value raises no pulse
    wrCtrl(cw(0, 0, 2'd2, 0, 1, 0, 3'd0, 0, 0));
    wrMatch(32'h0000_0077);
    wrCnt(32'h0000_0077);
    chk("R5 write no match", 32'(matEvt), 32'h0);
    edge1();
    chk("R5 write no match later", 32'(matEvt), 32'h0);

    // R10: input direction
    wrCtrl(cw(1, 0, 2'd0, 1, 0, 0, 3'd0, 0, 1));
    edge1();
    chk("R10 pinOe input", 32'(pinOe), 32'h0);
    chk("R10 pinOut input", 32'(pinOut), 32'h0);
    wrCtrl(cw(0, 0, 2'd0, 1, 0, 0, 3'd0, 0, 1));
    edge1();
    chk("R10 pinOe output", 32'(pinOe), 32'h1);
    chk("R7 R10 driven rest", 32'(pinOut), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule